// File: doc/BRIEF.md
# Dual-Bank Parallel IO Port

This block drives and samples 64 general-purpose digital lines from a host that can only move 32 bits at a time. The lines form two banks of 32. Each line has its own output-enable bit and output-data bit. A line whose enable is clear is left undriven, so the board's pull-up holds it high. The current state of every line can be read at any time, whatever its enable setting.

Writes from the host land first in per-bank staging registers, and a mode bit decides what happens next. In independent mode a write to a bank's data or enable word reaches that bank's pins on the clock edge of the write. In synchronized mode the staged words are held back. A single commit write then moves all four staged words (two data, two enable) to the pins on one clock edge, so a 64-bit pattern changes coherently. The pin inputs pass through a two-flop synchronizer before they can be read. A loopback bit feeds the block's own driven levels into that input path in place of the pins, for built-in test.

Top module: `dualbank_pio`

Register word indices: 0 lower data, 1 upper data, 2 lower enable, 3 upper enable, 4 control, 5 lower input, 6 upper input, 7 unmapped. Control bits: bit 0 = synchronized mode (1) / independent mode (0), bit 1 = commit, bit 2 = loopback. Bit i of a bank word belongs to line i of that bank; the upper bank holds lines 32 to 63.

## Requirements
- R1: After reset every line is disabled (pad_oe all 0), pad_out is all 0, and words 0 to 4 read 0, which selects independent mode with loopback off.
- R2: A line whose enable bit is 1 drives its data bit on pad_out. A line whose enable bit is 0 is not driven, so with a pull-up and no external driver it reads back as 1 in the input words.
- R3: In independent mode, a write to word 0, 1, 2 or 3 changes the matching bank's pad_out or pad_oe on the clock edge of the write. The other bank stays unchanged.
- R4: In synchronized mode, writes to words 0 to 3 update only the staged values and leave pad_out and pad_oe unchanged.
- R5: A write to word 4 with bit 1 set copies all four staged words to pad_out and pad_oe on that clock edge. Bit 1 always reads back as 0.
- R6: Words 0 to 3 read back the last value written to them. Word 4 reads bit 0 and bit 2 as last written, with all other bits 0.
- R7: Words 5 and 6 return the line levels of the lower and upper bank through a two-flop synchronizer. Writes to words 5, 6 and 7 change nothing, and word 7 reads 0.
- R8: With loopback set, words 5 and 6 show each line's internal level (the data bit when enabled, 1 when disabled) instead of pad_in. pad_out and pad_oe keep driving as before.
- R9: bus_rdata is registered. It shows the word addressed in the previous clock cycle, so a new address can be read on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data of the previous cycle's address |
| pad_in | input | 64 | Sensed line levels |
| pad_out | output | 64 | Active output data per line |
| pad_oe | output | 64 | Active output enable per line (1 = drive) |

## Verification
The pad outputs are due on the same edge that captures the write: pad_out and pad_oe change after that edge or not at all. The bench therefore samples them at the falling edge that follows each write strobe. Read data is due one edge after the address is presented, and the bench samples it at the next falling edge. An input word reflects a line change only three edges later: two synchronizer flops plus the read register. Before every input-word read the bench holds the lines and control still for three cycles. The expected values come from a bench-side model of the staged and active words, updated at each write.

// File: rtl/dualbank_pio_pkg.sv
package dualbank_pio_pkg;

  localparam int unsigned CB_MODE   = 0;
  localparam int unsigned CB_COMMIT = 1;
  localparam int unsigned CB_LOOP   = 2;

  typedef struct packed {
    logic loop_en;
    logic mode_sync;
  } ctrl_t;

  function automatic int unsigned addr_width(input int unsigned nbanks);
    return $clog2(3 * nbanks + 1);
  endfunction

  function automatic int unsigned ctrl_index(input int unsigned nbanks);
    return 2 * nbanks;
  endfunction

  function automatic int unsigned data_index(input int unsigned bank);
    return bank;
  endfunction

  function automatic int unsigned oe_index(input int unsigned nbanks, input int unsigned bank);
    return nbanks + bank;
  endfunction

  function automatic int unsigned in_index(input int unsigned nbanks, input int unsigned bank);
    return 2 * nbanks + 1 + bank;
  endfunction

endpackage

// File: rtl/pio_regs.sv
module pio_regs
  import dualbank_pio_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int NBANKS = 2,
  parameter int ADDR_W = 3
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           bus_wr,
  input  logic [ADDR_W-1:0]              bus_addr,
  input  logic [BANK_W-1:0]              bus_wdata,
  output logic [NBANKS-1:0][BANK_W-1:0]  stg_data,
  output logic [NBANKS-1:0][BANK_W-1:0]  stg_oe,
  output logic [NBANKS-1:0]              data_hit,
  output logic [NBANKS-1:0]              oe_hit,
  output ctrl_t                          ctrl_q,
  output logic                           commit_pulse
);

  localparam int unsigned CTRL_A = ctrl_index(NBANKS);

  logic ctrl_hit;

  assign ctrl_hit     = bus_wr && (bus_addr == ADDR_W'(CTRL_A));
  assign commit_pulse = ctrl_hit && bus_wdata[CB_COMMIT];

  for (genvar b = 0; b < NBANKS; b++) begin : g_stage
    assign data_hit[b] = bus_wr && (bus_addr == ADDR_W'(data_index(b)));
    assign oe_hit[b]   = bus_wr && (bus_addr == ADDR_W'(oe_index(NBANKS, b)));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_data[b] <= '0;
        stg_oe[b]   <= '0;
      end else begin
        if (data_hit[b]) stg_data[b] <= bus_wdata;
        if (oe_hit[b])   stg_oe[b]   <= bus_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (ctrl_hit) begin
      ctrl_q.mode_sync <= bus_wdata[CB_MODE];
      ctrl_q.loop_en   <= bus_wdata[CB_LOOP];
    end
  end

endmodule

// File: rtl/pio_bank_out.sv
module pio_bank_out #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_sync,
  input  logic              commit,
  input  logic              data_hit,
  input  logic              oe_hit,
  input  logic [BANK_W-1:0] wdata,
  input  logic [BANK_W-1:0] stg_data,
  input  logic [BANK_W-1:0] stg_oe,
  output logic [BANK_W-1:0] act_data,
  output logic [BANK_W-1:0] act_oe
);

  logic pass_through;

  assign pass_through = !mode_sync;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_data <= '0;
      act_oe   <= '0;
    end else if (commit) begin
      act_data <= stg_data;
      act_oe   <= stg_oe;
    end else if (pass_through) begin
      if (data_hit) act_data <= wdata;
      if (oe_hit)   act_oe   <= wdata;
    end
  end

endmodule

// File: rtl/pio_in_path.sv
module pio_in_path #(
  parameter int CH_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            loop_en,
  input  logic [CH_W-1:0] pad_in,
  input  logic [CH_W-1:0] act_data,
  input  logic [CH_W-1:0] act_oe,
  output logic [CH_W-1:0] in_word
);

  logic [CH_W-1:0] loop_level;
  logic [CH_W-1:0] src;
  logic [CH_W-1:0] sync_a;
  logic [CH_W-1:0] sync_b;

  function automatic logic [CH_W-1:0] pulled_level(input logic [CH_W-1:0] oe,
                                                   input logic [CH_W-1:0] dout);
    return (oe & dout) | ~oe;
  endfunction

  assign loop_level = pulled_level(act_oe, act_data);
  assign src        = loop_en ? loop_level : pad_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_a <= '1;
      sync_b <= '1;
    end else begin
      sync_a <= src;
      sync_b <= sync_a;
    end
  end

  assign in_word = sync_b;

endmodule

// File: rtl/dualbank_pio.sv
module dualbank_pio
  import dualbank_pio_pkg::*;
#(
  parameter int BANK_W = 32,
  parameter int NBANKS = 2,
  parameter int ADDR_W = addr_width(NBANKS)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [BANK_W-1:0]          bus_wdata,
  output logic [BANK_W-1:0]          bus_rdata,
  input  logic [NBANKS*BANK_W-1:0]   pad_in,
  output logic [NBANKS*BANK_W-1:0]   pad_out,
  output logic [NBANKS*BANK_W-1:0]   pad_oe
);

  localparam int CH_W = NBANKS * BANK_W;
  localparam int unsigned CTRL_A = ctrl_index(NBANKS);

  logic [NBANKS-1:0][BANK_W-1:0] stg_data;
  logic [NBANKS-1:0][BANK_W-1:0] stg_oe;
  logic [NBANKS-1:0][BANK_W-1:0] act_data;
  logic [NBANKS-1:0][BANK_W-1:0] act_oe;
  logic [NBANKS-1:0]             data_hit;
  logic [NBANKS-1:0]             oe_hit;
  ctrl_t                         ctrl_q;
  logic                          commit_pulse;
  logic [CH_W-1:0]               in_word;
  logic [BANK_W-1:0]             rd_next;

  function automatic logic [BANK_W-1:0] ctrl_word(input ctrl_t c);
    logic [BANK_W-1:0] w;
    w          = '0;
    w[CB_MODE] = c.mode_sync;
    w[CB_LOOP] = c.loop_en;
    return w;
  endfunction

  pio_regs #(
    .BANK_W(BANK_W), .NBANKS(NBANKS), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_addr     (bus_addr),
    .bus_wdata    (bus_wdata),
    .stg_data     (stg_data),
    .stg_oe       (stg_oe),
    .data_hit     (data_hit),
    .oe_hit       (oe_hit),
    .ctrl_q       (ctrl_q),
    .commit_pulse (commit_pulse)
  );

  for (genvar b = 0; b < NBANKS; b++) begin : g_bank
    pio_bank_out #(.BANK_W(BANK_W)) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_sync (ctrl_q.mode_sync),
      .commit    (commit_pulse),
      .data_hit  (data_hit[b]),
      .oe_hit    (oe_hit[b]),
      .wdata     (bus_wdata),
      .stg_data  (stg_data[b]),
      .stg_oe    (stg_oe[b]),
      .act_data  (act_data[b]),
      .act_oe    (act_oe[b])
    );
  end

  assign pad_out = act_data;
  assign pad_oe  = act_oe;

  pio_in_path #(.CH_W(CH_W)) u_in (
    .clk      (clk),
    .rst_n    (rst_n),
    .loop_en  (ctrl_q.loop_en),
    .pad_in   (pad_in),
    .act_data (act_data),
    .act_oe   (act_oe),
    .in_word  (in_word)
  );

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NBANKS; b++) begin
      if (bus_addr == ADDR_W'(data_index(b)))       rd_next = stg_data[b];
      if (bus_addr == ADDR_W'(oe_index(NBANKS, b))) rd_next = stg_oe[b];
      if (bus_addr == ADDR_W'(in_index(NBANKS, b))) rd_next = in_word[b*BANK_W +: BANK_W];
    end
    if (bus_addr == ADDR_W'(CTRL_A)) rd_next = ctrl_word(ctrl_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd_next;
  end

endmodule

// File: rtl/dualbank_pio_chk.sv
module dualbank_pio_chk #(
  parameter int BANK_W = 32,
  parameter int NBANKS = 2,
  parameter int ADDR_W = 3
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      bus_wr,
  input logic [ADDR_W-1:0]         bus_addr,
  input logic [BANK_W-1:0]         bus_wdata,
  input logic [BANK_W-1:0]         bus_rdata,
  input logic [NBANKS*BANK_W-1:0]  pad_out,
  input logic [NBANKS*BANK_W-1:0]  pad_oe,
  input logic                      mode_sync,
  input logic                      commit_pulse,
  input logic [NBANKS*BANK_W-1:0]  stg_data_flat,
  input logic [NBANKS*BANK_W-1:0]  stg_oe_flat
);

  localparam int CTRL_A   = 2 * NBANKS;
  localparam int UNMAPPED = 3 * NBANKS + 1;

  // R3: lower data write in independent mode reaches the lower pins at once
  a_r3_lower_direct: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && bus_wr && bus_addr == ADDR_W'(0))
      |=> pad_out[BANK_W-1:0] == $past(bus_wdata));

  // R3: the untouched upper bank keeps its level
  a_r3_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_sync && bus_wr && bus_addr == ADDR_W'(0))
      |=> $stable(pad_out[2*BANK_W-1:BANK_W]) && $stable(pad_oe));

  // R4: without a commit, synchronized mode freezes every pin
  a_r4_sync_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_sync && !commit_pulse) |=> $stable(pad_out) && $stable(pad_oe));

  // R5: commit moves all staged words to the pins on one edge
  a_r5_commit_copy: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |=> (pad_out == $past(stg_data_flat)) && (pad_oe == $past(stg_oe_flat)));

  // R5: the commit bit never reads back as set
  a_r5_commit_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(CTRL_A)) |=> !bus_rdata[1]);

  // R7: the unmapped word reads zero
  a_r7_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == ADDR_W'(UNMAPPED)) |=> bus_rdata == '0);

endmodule

bind dualbank_pio dualbank_pio_chk #(
  .BANK_W(BANK_W), .NBANKS(NBANKS), .ADDR_W(ADDR_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_wr        (bus_wr),
  .bus_addr      (bus_addr),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .pad_out       (pad_out),
  .pad_oe        (pad_oe),
  .mode_sync     (ctrl_q.mode_sync),
  .commit_pulse  (commit_pulse),
  .stg_data_flat (stg_data),
  .stg_oe_flat   (stg_oe)
);

// File: tb/sim_dualbank_pio.sv
`timescale 1ns/1ps
module sim_dualbank_pio;
  localparam int W  = 32;
  localparam int CH = 64;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [W-1:0]  bus_wdata = '0;
  wire  [W-1:0]  bus_rdata;
  wire  [CH-1:0] pad_out;
  wire  [CH-1:0] pad_oe;
  wire  [CH-1:0] pad_in;
  logic [CH-1:0] ext_en = '0;
  logic [CH-1:0] ext_val = '0;

  // board model: driven lines follow the block, others are pulled up unless driven externally
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ((ext_en & ext_val) | ~ext_en));

  always #5 clk = ~clk;

  dualbank_pio u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // model: index 0 lower data, 1 upper data, 2 lower enable, 3 upper enable
  logic [W-1:0] m_stg [4];
  logic [W-1:0] m_act [4];
  bit m_mode;
  bit m_lb;

  function automatic logic [CH-1:0] m_data();
    return {m_act[1], m_act[0]};
  endfunction

  function automatic logic [CH-1:0] m_oe();
    return {m_act[3], m_act[2]};
  endfunction

  function automatic logic [CH-1:0] m_line();
    logic [CH-1:0] d, e;
    d = m_data();
    e = m_oe();
    if (m_lb) return (e & d) | ~e;
    return (e & d) | (~e & ((ext_en & ext_val) | ~ext_en));
  endfunction

  function automatic logic [W-1:0] m_read(input int a);
    logic [CH-1:0] ln;
    ln = m_line();
    case (a)
      0, 1, 2, 3: return m_stg[a];
      4:          return {29'b0, m_lb, 1'b0, m_mode};
      5:          return ln[W-1:0];
      6:          return ln[CH-1:W];
      default:    return '0;
    endcase
  endfunction

  task automatic m_write(input int a, input logic [W-1:0] d);
    if (a <= 3) begin
      m_stg[a] = d;
      if (!m_mode) m_act[a] = d;
    end else if (a == 4) begin
      if (d[1]) for (int i = 0; i < 4; i++) m_act[i] = m_stg[i];
      m_mode = d[0];
      m_lb   = d[2];
    end
  endtask

  task automatic check(input string tag, input logic [CH-1:0] act, input logic [CH-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input string tag, input int a, input logic [W-1:0] d);
    bus_wr    = 1'b1;
    bus_addr  = AW'(a);
    bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    m_write(a, d);
    check({tag, " pad_out"}, pad_out, m_data());
    check({tag, " pad_oe"}, pad_oe, m_oe());
  endtask

  task automatic rd(input string tag, input int a);
    bus_addr = AW'(a);
    @(negedge clk);
    check(tag, {32'b0, bus_rdata}, {32'b0, m_read(a)});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int i = 0; i < 4; i++) begin
      m_stg[i] = '0;
      m_act[i] = '0;
    end
    m_mode = 1'b0;
    m_lb   = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);

    // R1 reset state
    check("R1 pad_oe after reset", pad_oe, '0);
    check("R1 pad_out after reset", pad_out, '0);
    for (int a = 0; a <= 4; a++) rd("R1 register reset value", a);
    // R2 pulled-up lines read 1, read back on consecutive cycles (R9)
    rd("R2 R9 lower input pulled up", 5);
    rd("R2 R9 upper input pulled up", 6);
    check("R2 all ones", {32'b0, bus_rdata}, {32'b0, 32'hFFFF_FFFF});

    // R3 independent updates, bank by bank
    wr("R3 lower data", 0, 32'hA5A5_0F0F);
    check("R3 upper pins untouched", pad_out[CH-1:W], '0);
    wr("R3 lower enable", 2, 32'hFFFF_0000);
    wr("R3 upper data", 1, 32'h1234_5678);
    wr("R3 upper enable", 3, 32'h00FF_00FF);
    idle(3);
    rd("R2 lower lines driven or pulled", 5);
    rd("R2 upper lines driven or pulled", 6);

    // R4 synchronized staging, R6 readback of staged words
    wr("R6 control sync", 4, 32'h0000_0001);
    wr("R4 staged upper data", 1, 32'hDEAD_BEEF);
    wr("R4 staged lower data", 0, 32'h0000_FFFF);
    wr("R4 staged lower enable", 2, 32'hFFFF_FFFF);
    wr("R4 staged upper enable", 3, 32'hFFFF_FFFF);
    rd("R6 staged upper data", 1);
    rd("R6 staged lower enable", 2);
    rd("R6 control readback", 4);
    // R5 commit releases all 64 lines together
    wr("R5 commit", 4, 32'h0000_0003);
    check("R5 full 64-bit pattern", pad_out, 64'hDEAD_BEEF_0000_FFFF);
    rd("R5 commit bit reads zero", 4);

    // R7 external inputs on disabled lines, writes to input words ignored
    wr("R3 back to independent", 4, 32'h0);
    wr("R7 disable lower", 2, 32'h0);
    wr("R7 disable upper", 3, 32'h0);
    ext_en  = 64'hFFFF_FFFF_0000_FFFF;
    ext_val = 64'h0F0F_1234_AAAA_5555;
    idle(3);
    rd("R7 lower input", 5);
    rd("R7 upper input", 6);
    wr("R7 write to input word", 5, 32'h0);
    wr("R7 write to unmapped", 7, 32'hFFFF_FFFF);
    idle(3);
    rd("R7 input unchanged", 5);
    rd("R7 unmapped reads zero", 7);

    // R8 loopback ignores pins and shows internal levels
    wr("R8 lower enable half", 2, 32'h0000_FFFF);
    wr("R8 loopback on", 4, 32'h0000_0004);
    idle(3);
    rd("R8 loopback lower", 5);
    rd("R8 loopback upper", 6);
    check("R8 pads still driven", pad_oe, {32'h0, 32'h0000_FFFF});
    wr("R8 loopback off", 4, 32'h0);

    // random mix of modes, commits, writes and line activity
    for (int it = 0; it < 400; it++) begin
      int a;
      logic [W-1:0] d;
      a = $urandom_range(0, 7);
      d = $urandom;
      if (a == 4 && $urandom_range(0, 1) == 0) d = d & 32'h7;
      wr("R3 R4 R5 random write", a, d);
      if ($urandom_range(0, 3) == 0) begin
        ext_en  = {$urandom, $urandom};
        ext_val = {$urandom, $urandom};
      end
      idle(3);
      rd("R6 R7 R8 R9 random read", $urandom_range(0, 7));
    end

    done = 1'b1;
    summary();
    $finish;
  end

endmodule